// File: doc/BRIEF.md
# Memory-Mapped Slave Access Checker and Read-Error Reporter

This block guards the slave side of a memory-mapped read/write port whose accesses a downstream request engine turns into remote read and write transactions. Each access that arrives is inspected when it is accepted: its burst length, its byte-lane mask and the span of bytes it covers, compared against a programmable address window. Violations latch into sticky status bits. An enable mask, set through a two-entry register port, selects which status bits drive a level interrupt line.

Accepted accesses go to the request engine as a one-cycle request pulse. For reads, the block returns one data beat per requested word. Beats from the engine's completions are passed through, tagged with the completion's error indication. A rejected read issues no request, and the block answers it with filler beats of zero data that carry the error flag. A read that times out partway through is completed with filler error beats. Every read therefore returns its full beat count, and the error flag on the read data can come from three causes: an error completion, a timeout, or a rejection.

Top module: `mm_slave_err_rpt`

## Requirements
- R1: Six sticky status bits are readable at register address 0 and the enable mask at address 1. `regRdata` shows the selected register in the same cycle. Bit meanings: 0 = bad read burst count, 1 = bad read byte lanes, 2 = bad write byte lanes, 3 = bad write burst count, 4 = write outside window, 5 = read outside window. A status bit, once set, stays set until software clears it.
- R2: A register write to address 0 clears each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. A register write to address 1 loads the enable mask.
- R3: `irq` is high exactly while some status bit and the matching enable bit are both 1.
- R4: A burst count of 0, or one above `MAX_BURST`, is invalid and sets bit 0 (reads) or bit 3 (writes). A count of 0 is then handled as a single beat.
- R5: A read needs all byte lanes enabled, otherwise bit 1 is set. A single-beat write needs at least one lane enabled. Every beat of a multi-beat write needs all lanes enabled. A write that breaks either rule sets bit 2.
- R6: An access lies inside the window only when its first byte address and its last byte address (first + count*bytes-per-word - 1) both lie within [`winBase`, `winLimit`], bounds included. Otherwise bit 5 (read) or bit 4 (write) is set.
- R7: An access that passes every check raises `reqValid` in its acceptance cycle, with `reqWrite` high for writes. A rejected access raises no request.
- R8: Each completion beat (`cplValid`) of an accepted read appears on `rdValid`/`rdData` one cycle later, with `rdError` equal to `cplError`.
- R9: If `cplTimeout` arrives while read beats are still outstanding, every remaining beat is delivered as an error beat with zero data.
- R10: A rejected read returns max(count,1) beats, each with `rdError` high and zero data.
- R11: `busWait` is high from the cycle after a read is accepted until its last beat is delivered. No access is accepted while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access's first word |
| busBurst | input | BURST_W | Beats in the access |
| busByteEn | input | DATA_W/8 | Byte-lane mask of the current beat |
| busRead | input | 1 | Read access request |
| busWrite | input | 1 | Write beat present |
| busWait | output | 1 | Slave busy with a read |
| winBase | input | ADDR_W | Lowest byte address inside the window |
| winLimit | input | ADDR_W | Highest byte address inside the window |
| reqValid | output | 1 | Pulse: request issued to the engine |
| reqWrite | output | 1 | Issued request is a write |
| cplValid | input | 1 | Completion beat from the engine |
| cplError | input | 1 | Completion beat carries error status |
| cplTimeout | input | 1 | Outstanding read has timed out |
| cplData | input | DATA_W | Completion beat data |
| rdValid | output | 1 | Read data beat valid |
| rdData | output | DATA_W | Read data |
| rdError | output | 1 | Error flag for this read beat |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| regWrite | input | 1 | Register write strobe |
| regWdata | input | 6 | Register write data |
| regRdata | output | 6 | Selected register contents |
| irq | output | 1 | Interrupt line |

## Verification
Reads run through four distinct situations: clean completions, a completion with one error beat inside a burst, a timeout after a partial burst, and rejected reads. The rejected reads cover a span that starts inside the window but ends past it, a start below the window, burst counts of 0 and above the maximum, and a partial lane mask. Together these separate the three error sources and show that the beat count is preserved in every case. Writes cover a clean burst, a lane violation on a later beat only, an empty single-beat lane mask, a zero count and an address outside the window, so each status bit is set in isolation. The register port is exercised with write-zero and write-one clears and with masked and unmasked enables, which separates stickiness from interrupt gating.

// File: rtl/mmser_pkg.sv
package mmser_pkg;
  localparam int NUM_ERR = 6;
  // status bit positions (software-visible)
  localparam int E_RD_CNT = 0;
  localparam int E_RD_BE  = 1;
  localparam int E_WR_BE  = 2;
  localparam int E_WR_CNT = 3;
  localparam int E_WR_OOB = 4;
  localparam int E_RD_OOB = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_WAIT, ST_FILL} ctrlState_t;

  typedef struct packed {
    logic               passBeat;
    logic               fillBeat;
    logic [NUM_ERR-1:0] setMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/mmser_check.sv
module mmser_check #(
  parameter int ADDR_W    = 16,
  parameter int BURST_W   = 4,
  parameter int BE_W      = 4,
  parameter int MAX_BURST = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BURST_W-1:0] burst,
  input  logic [BE_W-1:0]    byteEn,
  input  logic [ADDR_W-1:0]  winBase,
  input  logic [ADDR_W-1:0]  winLimit,
  output logic               cntBad,
  output logic               beFull,
  output logic               beNone,
  output logic               inBounds,
  output logic [BURST_W-1:0] effCnt
);
  localparam int SPAN_W = ADDR_W + BURST_W + 2;
  localparam logic [SPAN_W-1:0] BYTES = SPAN_W'(BE_W);

  logic [SPAN_W-1:0] firstByte;
  logic [SPAN_W-1:0] lastByte;

  always_comb begin
    cntBad    = (burst == '0) || (int'(burst) > MAX_BURST);
    effCnt    = (burst == '0) ? BURST_W'(1) : burst;
    beFull    = &byteEn;
    beNone    = (byteEn == '0);
    firstByte = SPAN_W'(addr);
    lastByte  = firstByte + SPAN_W'(effCnt) * BYTES - SPAN_W'(1);
    inBounds  = (firstByte >= SPAN_W'(winBase)) && (firstByte <= SPAN_W'(winLimit))
             && (lastByte  >= SPAN_W'(winBase)) && (lastByte  <= SPAN_W'(winLimit));
  end
endmodule

// File: rtl/mmser_ctrl.sv
module mmser_ctrl
  import mmser_pkg::*;
#(
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busRead,
  input  logic               busWrite,
  input  logic               cplValid,
  input  logic               cplTimeout,
  input  logic               cntBad,
  input  logic               beFull,
  input  logic               beNone,
  input  logic               inBounds,
  input  logic [BURST_W-1:0] effCnt,
  output ctrlStrobe_t        strobe,
  output logic               reqValid,
  output logic               reqWrite,
  output logic               busWait
);
  ctrlState_t         state, nextState;
  logic [BURST_W-1:0] beatsLeft, nextLeft;
  logic               lastBeat;
  logic               multiBeat;
  logic               wrLaneBad;

  assign lastBeat  = (beatsLeft == BURST_W'(1));
  assign multiBeat = (effCnt > BURST_W'(1));
  assign wrLaneBad = multiBeat ? !beFull : beNone;
  assign busWait   = (state == ST_WAIT) || (state == ST_FILL);

  always_comb begin
    nextState = state;
    nextLeft  = beatsLeft;
    strobe    = '0;
    reqValid  = 1'b0;
    reqWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (busRead) begin
          strobe.setMask[E_RD_CNT] = cntBad;
          strobe.setMask[E_RD_BE]  = !beFull;
          strobe.setMask[E_RD_OOB] = !inBounds;
          nextLeft = effCnt;
          if (!cntBad && beFull && inBounds) begin
            reqValid  = 1'b1;
            nextState = ST_WAIT;
          end else begin
            nextState = ST_FILL;
          end
        end else if (busWrite) begin
          strobe.setMask[E_WR_CNT] = cntBad;
          strobe.setMask[E_WR_BE]  = wrLaneBad;
          strobe.setMask[E_WR_OOB] = !inBounds;
          reqValid = !cntBad && !wrLaneBad && inBounds;
          reqWrite = reqValid;
          if (multiBeat) begin
            nextLeft  = effCnt - BURST_W'(1);
            nextState = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (busWrite) begin
          strobe.setMask[E_WR_BE] = !beFull;
          nextLeft = beatsLeft - BURST_W'(1);
          if (lastBeat) nextState = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (cplValid) begin
          strobe.passBeat = 1'b1;
          nextLeft = beatsLeft - BURST_W'(1);
          if (lastBeat) nextState = ST_IDLE;
        end else if (cplTimeout) begin
          nextState = ST_FILL;
        end
      end
      ST_FILL: begin
        strobe.fillBeat = 1'b1;
        nextLeft = beatsLeft - BURST_W'(1);
        if (lastBeat) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
    end else begin
      state     <= nextState;
      beatsLeft <= nextLeft;
    end
  end
endmodule

// File: rtl/mmser_datapath.sv
module mmser_datapath
  import mmser_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               cplError,
  input  logic [DATA_W-1:0]  cplData,
  input  logic               regAddr,
  input  logic               regWrite,
  input  logic [NUM_ERR-1:0] regWdata,
  output logic [NUM_ERR-1:0] statusVec,
  output logic [NUM_ERR-1:0] enableVec,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdError
);
  logic [NUM_ERR-1:0] clearMask;

  assign clearMask = (regWrite && !regAddr) ? regWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusVec <= '0;
      enableVec <= '0;
    end else begin
      // a new violation wins over a clear in the same cycle
      statusVec <= (statusVec & ~clearMask) | strobe.setMask;
      if (regWrite && regAddr) enableVec <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdError <= 1'b0;
    end else begin
      rdValid <= strobe.passBeat | strobe.fillBeat;
      rdData  <= strobe.passBeat ? cplData : '0;
      rdError <= strobe.fillBeat | (strobe.passBeat & cplError);
    end
  end
endmodule

// File: rtl/mm_slave_err_rpt.sv
module mm_slave_err_rpt
  import mmser_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BURST_W   = 4,
  parameter int MAX_BURST = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BURST_W-1:0]  busBurst,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic                busRead,
  input  logic                busWrite,
  output logic                busWait,
  input  logic [ADDR_W-1:0]   winBase,
  input  logic [ADDR_W-1:0]   winLimit,
  output logic                reqValid,
  output logic                reqWrite,
  input  logic                cplValid,
  input  logic                cplError,
  input  logic                cplTimeout,
  input  logic [DATA_W-1:0]   cplData,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdError,
  input  logic                regAddr,
  input  logic                regWrite,
  input  logic [5:0]          regWdata,
  output logic [5:0]          regRdata,
  output logic                irq
);
  localparam int BE_W = DATA_W / 8;

  ctrlStrobe_t        strobe;
  logic               cntBad, beFull, beNone, inBounds;
  logic [BURST_W-1:0] effCnt;
  logic [NUM_ERR-1:0] statusVec, enableVec;

  mmser_check #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .BE_W(BE_W), .MAX_BURST(MAX_BURST)
  ) uCheck (
    .addr(busAddr), .burst(busBurst), .byteEn(busByteEn),
    .winBase(winBase), .winLimit(winLimit),
    .cntBad(cntBad), .beFull(beFull), .beNone(beNone),
    .inBounds(inBounds), .effCnt(effCnt)
  );

  mmser_ctrl #(.BURST_W(BURST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busRead(busRead), .busWrite(busWrite),
    .cplValid(cplValid), .cplTimeout(cplTimeout),
    .cntBad(cntBad), .beFull(beFull), .beNone(beNone),
    .inBounds(inBounds), .effCnt(effCnt),
    .strobe(strobe), .reqValid(reqValid), .reqWrite(reqWrite),
    .busWait(busWait)
  );

  mmser_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cplError(cplError), .cplData(cplData),
    .regAddr(regAddr), .regWrite(regWrite), .regWdata(regWdata),
    .statusVec(statusVec), .enableVec(enableVec),
    .rdValid(rdValid), .rdData(rdData), .rdError(rdError)
  );

  assign regRdata = regAddr ? enableVec : statusVec;
  assign irq      = |(statusVec & enableVec);
endmodule

// File: rtl/mmser_checker.sv
module mmser_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRead,
  input logic              busWait,
  input logic [ADDR_W-1:0] busAddr,
  input logic [ADDR_W-1:0] winBase,
  input logic              reqValid,
  input logic              cplValid,
  input logic [DATA_W-1:0] cplData,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              rdError,
  input logic              regAddr,
  input logic              regWrite,
  input logic [5:0]        regWdata,
  input logic              irq,
  input logic [5:0]        statusVec
);
  // R11
  req_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !busWait);

  // R7
  below_window_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busWait && (busAddr < winBase)) |-> !reqValid);

  // R10
  filler_beat_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !$past(cplValid)) |-> (rdError && (rdData == '0)));

  // R8
  pass_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(cplValid)) |-> (rdData == $past(cplData)));

  // R1
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrite && !regAddr) |-> ((statusVec & $past(statusVec)) == $past(statusVec)));

  // R2
  w1c_keeps_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrite && !regAddr)
      |-> ((statusVec & $past(statusVec & ~regWdata)) == $past(statusVec & ~regWdata)));

  // R3
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrite && regAddr && (regWdata == '0)) |-> !irq);
endmodule

bind mm_slave_err_rpt mmser_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busRead(busRead), .busWait(busWait),
  .busAddr(busAddr), .winBase(winBase), .reqValid(reqValid),
  .cplValid(cplValid), .cplData(cplData), .rdValid(rdValid),
  .rdData(rdData), .rdError(rdError), .regAddr(regAddr),
  .regWrite(regWrite), .regWdata(regWdata), .irq(irq),
  .statusVec(statusVec)
);

// File: tb/mm_slave_err_rpt_test.sv
module mm_slave_err_rpt_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int BURST_W = 4;
  localparam int BE_W = DATA_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [BURST_W-1:0] busBurst = '0;
  logic [BE_W-1:0] busByteEn = '0;
  logic busRead = 1'b0, busWrite = 1'b0, busWait;
  logic [ADDR_W-1:0] winBase = 16'h1000, winLimit = 16'h1FFF;
  logic reqValid, reqWrite;
  logic cplValid = 1'b0, cplError = 1'b0, cplTimeout = 1'b0;
  logic [DATA_W-1:0] cplData = '0;
  logic rdValid, rdError;
  logic [DATA_W-1:0] rdData;
  logic regAddr = 1'b0, regWrite = 1'b0;
  logic [5:0] regWdata = '0, regRdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [DATA_W:0] expQ[$];  // {error, data}

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_slave_err_rpt uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busBurst(busBurst),
    .busByteEn(busByteEn), .busRead(busRead), .busWrite(busWrite),
    .busWait(busWait), .winBase(winBase), .winLimit(winLimit),
    .reqValid(reqValid), .reqWrite(reqWrite), .cplValid(cplValid),
    .cplError(cplError), .cplTimeout(cplTimeout), .cplData(cplData),
    .rdValid(rdValid), .rdData(rdData), .rdError(rdError),
    .regAddr(regAddr), .regWrite(regWrite), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every delivered read beat
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk("R10 unexpected beat", {31'd0, rdError, rdData}, 64'h0);
      end else begin
        logic [DATA_W:0] e;
        e = expQ.pop_front();
        chk("R8/R9/R10 read beat", {31'd0, rdError, rdData}, {31'd0, e});
      end
    end
  end

  task automatic regWr(input logic a, input logic [5:0] d);
    @(negedge clk);
    regAddr = a; regWrite = 1'b1; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic regChk(input string req, input logic a, input logic [5:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, 64'(regRdata), 64'(exp));
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busWait) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // issues a read; on rejection pushes filler beats
  task automatic doRead(input string req, input logic [ADDR_W-1:0] a, input int n,
                        input logic [BE_W-1:0] be, input bit expReq);
    @(negedge clk);
    busAddr = a; busBurst = BURST_W'(n); busByteEn = be; busRead = 1'b1;
    #1;
    chk({req, " R7 read request"}, 64'(reqValid), 64'(expReq));
    if (!expReq) for (int i = 0; i < ((n == 0) ? 1 : n); i++) expQ.push_back({1'b1, 32'h0});
    @(negedge clk);
    busRead = 1'b0;
    #1;
    chk("R11 busy after read", 64'(busWait), 64'd1);
  endtask

  // engine returns n beats; beat errIdx carries error; timeout after toAfter beats
  task automatic engine(input int n, input int errIdx, input int toAfter, input logic [31:0] seed);
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i == toAfter) begin
        cplTimeout = 1'b1;
        for (int j = i; j < n; j++) expQ.push_back({1'b1, 32'h0});
        @(negedge clk);
        cplTimeout = 1'b0;
        break;
      end
      cplValid = 1'b1; cplError = (i == errIdx); cplData = seed + 32'(i);
      expQ.push_back({(i == errIdx), seed + 32'(i)});
      @(negedge clk);
      cplValid = 1'b0; cplError = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic doWrite(input string req, input logic [ADDR_W-1:0] a, input int n,
                         input logic [BE_W-1:0] be1, input logic [BE_W-1:0] beRest,
                         input bit expReq);
    @(negedge clk);
    busAddr = a; busBurst = BURST_W'(n); busByteEn = be1; busWrite = 1'b1;
    #1;
    chk({req, " R7 write request"}, 64'(reqValid), 64'(expReq));
    if (expReq) chk({req, " R7 write flag"}, 64'(reqWrite), 64'd1);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      busByteEn = beRest;
    end
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic statusExpectClear(input string req, input logic [5:0] exp);
    regChk(req, 1'b0, exp);
    regWr(1'b0, 6'h3F);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state (R1, R3, R11)
    regChk("R1 reset status", 1'b0, 6'h00);
    regChk("R1 reset enable", 1'b1, 6'h00);
    chk("R3 reset irq", 64'(irq), 64'd0);
    chk("R11 reset busWait", 64'(busWait), 64'd0);

    // clean read, 4 beats (R8)
    doRead("R8 clean", 16'h1000, 4, 4'hF, 1'b1);
    engine(4, -1, -1, 32'hA000);
    waitIdle();
    chk("R11 idle after read", 64'(busWait), 64'd0);
    regChk("R8 clean no status", 1'b0, 6'h00);

    // error completion on beat 2, all 4 beats still delivered (R8)
    doRead("R8 errbeat", 16'h1100, 4, 4'hF, 1'b1);
    engine(4, 2, -1, 32'hB000);
    waitIdle();

    // timeout after 1 beat: 3 filler error beats (R9)
    doRead("R9 timeout", 16'h1200, 4, 4'hF, 1'b1);
    engine(4, -1, 1, 32'hC000);
    waitIdle();

    // last byte beyond limit, first inside: rejected, bit 5 (R6, R10)
    doRead("R6 span past limit", 16'h1FF8, 4, 4'hF, 1'b0);
    waitIdle();
    regChk("R6 read oob bit5", 1'b0, 6'h20);
    chk("R3 irq masked", 64'(irq), 64'd0);
    regWr(1'b1, 6'h20);
    #1 chk("R3 irq enabled", 64'(irq), 64'd1);
    regWr(1'b0, 6'h00);
    regChk("R2 write zero keeps", 1'b0, 6'h20);
    regWr(1'b0, 6'h20);
    regChk("R2 write one clears", 1'b0, 6'h00);
    #1 chk("R3 irq after clear", 64'(irq), 64'd0);
    regWr(1'b1, 6'h3F);

    // exact-fit span at the top of the window (R6)
    doRead("R6 exact fit", 16'h1FF0, 4, 4'hF, 1'b1);
    engine(4, -1, -1, 32'hD000);
    waitIdle();
    regChk("R6 exact fit no status", 1'b0, 6'h00);

    // start below base (R6, R10)
    doRead("R6 below base", 16'h0FFC, 1, 4'hF, 1'b0);
    waitIdle();
    chk("R3 irq on", 64'(irq), 64'd1);
    statusExpectClear("R6 below base bit5", 6'h20);

    // burst counts 0 and 9 (R4, R10)
    doRead("R4 zero count", 16'h1000, 0, 4'hF, 1'b0);
    waitIdle();
    statusExpectClear("R4 read count bit0", 6'h01);
    doRead("R4 count over max", 16'h1000, 9, 4'hF, 1'b0);
    waitIdle();
    statusExpectClear("R4 read count bit0 over", 6'h01);

    // partial read lanes (R5)
    doRead("R5 read lanes", 16'h1000, 1, 4'h7, 1'b0);
    waitIdle();
    statusExpectClear("R5 read lanes bit1", 6'h02);

    // writes
    doWrite("R7 clean write", 16'h1000, 2, 4'hF, 4'hF, 1'b1);
    regChk("R7 clean write no status", 1'b0, 6'h00);
    doWrite("R5 later beat lanes", 16'h1000, 2, 4'hF, 4'h3, 1'b1);
    statusExpectClear("R5 write later lanes bit2", 6'h04);
    doWrite("R5 single empty lanes", 16'h1000, 1, 4'h0, 4'h0, 1'b0);
    statusExpectClear("R5 write empty bit2", 6'h04);
    doWrite("R5 single partial ok", 16'h1000, 1, 4'h1, 4'h0, 1'b1);
    regChk("R5 single partial no status", 1'b0, 6'h00);
    doWrite("R4 write zero count", 16'h1000, 0, 4'hF, 4'hF, 1'b0);
    statusExpectClear("R4 write count bit3", 6'h08);
    doWrite("R6 write oob", 16'h2000, 1, 4'hF, 4'hF, 1'b0);
    statusExpectClear("R6 write oob bit4", 6'h10);
    #1 chk("R3 irq off at end", 64'(irq), 64'd0);

    repeat (4) @(negedge clk);
    chk("R10 scoreboard drained", 64'(expQ.size()), 64'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule